// File: doc/BRIEF.md
# Emission Diary with Threshold Recall

A sieving station sends contributions down a long pipelined summation bus. Each contribution names a progression and the sieve location it targets. The diary keeps a short-lived record of every contribution the station has sent. Each record lives only as long as its location can still be inside the bus pipeline. When the threshold unit at the end of the bus finds a location whose summed weight is high enough, it broadcasts that location to every station. Each diary then replays the progression ids that contributed to it.

Records sit in a circular store of fixed size, and each one is stamped with the cycle it was written in. A record whose age has grown past the configured pipeline latency drops out without being reported, and its slot is free to be written again. A broadcast takes a snapshot of every live record that carries the reported location. The matches then stream out one per cycle, oldest first, while new contributions keep being recorded. If a contribution arrives while every slot holds a live record, the oldest record is overwritten and a one-cycle flag reports it.

Top module: `emission_diary`

## Requirements
- R1: Every cycle with `emitValid` high writes one record (`emitId`, `emitLoc`). A later recall of that location that arrives within the retention window returns this record.
- R2: A record written at clock edge e matches a report sampled at edge e+PIPE_LAT. It does not match a report sampled at edge e+PIPE_LAT+1 or later (PIPE_LAT defaults to 40).
- R3: A report accepted at edge r drives `recValid` high from the cycle after r, showing one matching record per cycle with its id and location. Records appear oldest first, and the stream is gap-free until the matches are exhausted.
- R4: `busy` is high exactly in the cycles in which a recalled record is being presented on the output.
- R5: A report that arrives while `busy` is high is ignored and adds nothing to the stream. A report that matches no live record leaves `busy` and `recValid` low.
- R6: Contributions that arrive during a recall are recorded, and a later report can recall them.
- R7: A contribution written into a slot whose record is still live overwrites the oldest record, which is then never recalled. `overwrite` is high for exactly the cycle after that write.
- R8: A contribution sampled on the same edge as an accepted report is not part of that report's recall.
- R9: While reset is held, `busy`, `recValid` and `overwrite` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| emitValid | input | 1 | A contribution is sent this cycle |
| emitId | input | ID_W | Progression id of the contribution |
| emitLoc | input | LOC_W | Target sieve location tag |
| rptValid | input | 1 | Threshold unit broadcasts a passing location |
| rptLoc | input | LOC_W | Location tag being reported |
| recValid | output | 1 | A recalled record is presented |
| recId | output | ID_W | Progression id of the recalled record |
| recLoc | output | LOC_W | Location tag of the recalled record |
| busy | output | 1 | A recall stream is in progress |
| overwrite | output | 1 | A live record was overwritten on the previous edge |

## Verification
Recording and recall collide in two ways. A contribution can land on the same edge as the report that starts a recall, or it can arrive while a stream is running and overwrite a slot still waiting to be replayed. Both are provoked on purpose: a report and a contribution to the same location are driven together, and contributions are sent back to back during a recall. Random phases at a dense emission rate then mix these cases with overflow. A list-based model of the contribution history settles every cycle which records are live, which are pending, and whether the flag must be raised. It compares the result against the stream.

// File: rtl/diary_pkg.sv
package diary_pkg;

  // Strobes from control to the record store, valid for one cycle.
  typedef struct packed {
    logic write;    // record the incoming contribution
    logic capture;  // snapshot matches of the reported location
    logic pop;      // retire the record shown this cycle
  } diaryCmd_t;

  typedef enum logic {
    DIARY_IDLE   = 1'b0,
    DIARY_RECALL = 1'b1
  } diaryState_t;

endpackage

// File: rtl/diary_datapath.sv
module diary_datapath
  import diary_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int ID_W     = 8,
  parameter int LOC_W    = 12,
  parameter int PIPE_LAT = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  diaryCmd_t        cmd,
  input  logic [ID_W-1:0]  emitId,
  input  logic [LOC_W-1:0] emitLoc,
  input  logic [LOC_W-1:0] rptLoc,
  output logic             outValid,
  output logic [ID_W-1:0]  outId,
  output logic [LOC_W-1:0] outLoc,
  output logic             liveOverwrite,
  output logic             pendNextAny
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  // Timestamps only need to span one retention window plus margin.
  localparam int TS_W = $clog2(PIPE_LAT + 2) + 1;
  localparam logic [TS_W-1:0] LAT_TS = TS_W'(PIPE_LAT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  logic [TS_W-1:0]  now;
  logic [IDX_W-1:0] wrPtr;
  logic             slotValid [SLOTS];
  logic [ID_W-1:0]  slotId    [SLOTS];
  logic [LOC_W-1:0] slotLoc   [SLOTS];
  logic [TS_W-1:0]  slotTs    [SLOTS];

  logic [SLOTS-1:0] liveMask;
  logic [SLOTS-1:0] hitMask;
  logic [SLOTS-1:0] pendMask;
  logic [SLOTS-1:0] pendNext;
  logic [SLOTS-1:0] wrMask;
  logic [SLOTS-1:0] popMask;
  logic [IDX_W-1:0] selIdx;
  logic             selFound;

  // Age test and location compare per slot.
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic [TS_W-1:0] age;
    assign age         = now - slotTs[g];
    assign liveMask[g] = slotValid[g] && (age <= LAT_TS);
    assign hitMask[g]  = liveMask[g] && (slotLoc[g] == rptLoc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      now   <= '0;
      wrPtr <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        slotValid[i] <= 1'b0;
        slotId[i]    <= '0;
        slotLoc[i]   <= '0;
        slotTs[i]    <= '0;
      end
    end else begin
      now <= now + 1'b1;
      for (int i = 0; i < SLOTS; i++) begin
        if (wrMask[i]) begin
          slotValid[i] <= 1'b1;
          slotId[i]    <= emitId;
          slotLoc[i]   <= emitLoc;
          slotTs[i]    <= now;
        end else begin
          // Expired records are dropped so their stamps never alias.
          slotValid[i] <= liveMask[i];
        end
      end
      if (cmd.write) begin
        wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      end
    end
  end

  assign wrMask        = cmd.write ? (SLOTS'(1) << wrPtr) : '0;
  assign liveOverwrite = cmd.write && liveMask[wrPtr];

  // Oldest pending record: scan forward from the write pointer.
  always_comb begin
    selIdx   = '0;
    selFound = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      int j;
      j = int'(wrPtr) + k;
      if (j >= SLOTS) j = j - SLOTS;
      if (!selFound && pendMask[j]) begin
        selFound = 1'b1;
        selIdx   = IDX_W'(j);
      end
    end
  end

  assign popMask     = (cmd.pop && selFound) ? (SLOTS'(1) << selIdx) : '0;
  assign pendNext    = (cmd.capture ? hitMask : (pendMask & ~popMask)) & ~wrMask;
  assign pendNextAny = |pendNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendMask <= '0;
    else       pendMask <= pendNext;
  end

  assign outValid = selFound;
  assign outId    = slotId[selIdx];
  assign outLoc   = slotLoc[selIdx];

endmodule

// File: rtl/diary_ctrl.sv
module diary_ctrl
  import diary_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      emitValid,
  input  logic      rptValid,
  input  logic      liveOverwrite,
  input  logic      pendNextAny,
  output diaryCmd_t cmd,
  output logic      busy,
  output logic      overwrite
);

  diaryState_t state;

  assign busy        = (state == DIARY_RECALL);
  assign cmd.write   = emitValid;
  assign cmd.capture = rptValid && (state == DIARY_IDLE);
  assign cmd.pop     = (state == DIARY_RECALL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= DIARY_IDLE;
      overwrite <= 1'b0;
    end else begin
      state     <= pendNextAny ? DIARY_RECALL : DIARY_IDLE;
      overwrite <= liveOverwrite;
    end
  end

endmodule

// File: rtl/emission_diary.sv
module emission_diary
  import diary_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int ID_W     = 8,
  parameter int LOC_W    = 12,
  parameter int PIPE_LAT = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             emitValid,
  input  logic [ID_W-1:0]  emitId,
  input  logic [LOC_W-1:0] emitLoc,
  input  logic             rptValid,
  input  logic [LOC_W-1:0] rptLoc,
  output logic             recValid,
  output logic [ID_W-1:0]  recId,
  output logic [LOC_W-1:0] recLoc,
  output logic             busy,
  output logic             overwrite
);

  diaryCmd_t cmd;
  logic      liveOverwrite;
  logic      pendNextAny;

  diary_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .emitValid    (emitValid),
    .rptValid     (rptValid),
    .liveOverwrite(liveOverwrite),
    .pendNextAny  (pendNextAny),
    .cmd          (cmd),
    .busy         (busy),
    .overwrite    (overwrite)
  );

  diary_datapath #(
    .SLOTS   (SLOTS),
    .ID_W    (ID_W),
    .LOC_W   (LOC_W),
    .PIPE_LAT(PIPE_LAT)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .emitId       (emitId),
    .emitLoc      (emitLoc),
    .rptLoc       (rptLoc),
    .outValid     (recValid),
    .outId        (recId),
    .outLoc       (recLoc),
    .liveOverwrite(liveOverwrite),
    .pendNextAny  (pendNextAny)
  );

endmodule

// File: rtl/diary_checker.sv
module diary_checker #(
  parameter int LOC_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             emitValid,
  input logic             rptValid,
  input logic [LOC_W-1:0] rptLoc,
  input logic             recValid,
  input logic [LOC_W-1:0] recLoc,
  input logic             busy,
  input logic             overwrite
);

  // Location of the last report the diary was free to accept.
  logic [LOC_W-1:0] capLoc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  capLoc <= '0;
    else if (rptValid && !busy) capLoc <= rptLoc;
  end

  assert_stream_loc_R3: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> (recLoc == capLoc));

  assert_busy_tracks_stream_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy == recValid);

  assert_busy_needs_report_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(rptValid));

  assert_busy_ends_after_record_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(recValid));

  assert_overwrite_needs_emit_R7: assert property (@(posedge clk) disable iff (!rstN)
    overwrite |-> $past(emitValid));

endmodule

bind emission_diary diary_checker #(.LOC_W(LOC_W)) u_diaryChk (
  .clk      (clk),
  .rstN     (rstN),
  .emitValid(emitValid),
  .rptValid (rptValid),
  .rptLoc   (rptLoc),
  .recValid (recValid),
  .recLoc   (recLoc),
  .busy     (busy),
  .overwrite(overwrite)
);

// File: tb/tb_emission_diary.sv
module tb_emission_diary;

  localparam int SLOTS = 32;
  localparam int ID_W  = 8;
  localparam int LOC_W = 12;
  localparam int LAT   = 40;
  localparam int MAXEM = 8192;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN;
  logic             emitValid;
  logic [ID_W-1:0]  emitId;
  logic [LOC_W-1:0] emitLoc;
  logic             rptValid;
  logic [LOC_W-1:0] rptLoc;
  logic             recValid;
  logic [ID_W-1:0]  recId;
  logic [LOC_W-1:0] recLoc;
  logic             busy;
  logic             overwrite;

  emission_diary #(.SLOTS(SLOTS), .ID_W(ID_W), .LOC_W(LOC_W), .PIPE_LAT(LAT)) dut (
    .clk(clk), .rstN(rstN), .emitValid(emitValid), .emitId(emitId), .emitLoc(emitLoc),
    .rptValid(rptValid), .rptLoc(rptLoc), .recValid(recValid), .recId(recId),
    .recLoc(recLoc), .busy(busy), .overwrite(overwrite)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // History model: emission n lives in slot n mod SLOTS.
  int emIdA  [MAXEM];
  int emLocA [MAXEM];
  int emTA   [MAXEM];
  int nEm  = 0;
  int tNow = 0;
  int pend [$];
  bit ovfExp = 0;

  function automatic bit isLive(int j, int t);
    return (j < nEm) && (t - emTA[j] <= LAT) && (nEm <= j + SLOTS);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelCheck();
    chk("R4", "busy", int'(busy), int'(pend.size() > 0));
    chk("R3", "recValid", int'(recValid), int'(pend.size() > 0));
    if (pend.size() > 0) begin
      chk("R3", "recId", int'(recId), emIdA[pend[0]]);
      chk("R3", "recLoc", int'(recLoc), emLocA[pend[0]]);
    end
    chk("R7", "overwrite", int'(overwrite), int'(ovfExp));
  endtask

  // Drive one cycle at a falling edge, advance the model at the rising
  // edge, then check at the next falling edge.
  task automatic step(bit ev, int id, int loc, bit rv, int rloc);
    emitValid = ev;
    emitId    = ID_W'(id);
    emitLoc   = LOC_W'(loc);
    rptValid  = rv;
    rptLoc    = LOC_W'(rloc);
    @(posedge clk);
    #1;
    if (pend.size() > 0) begin
      void'(pend.pop_front());
    end else if (rv) begin
      for (int j = 0; j < nEm; j++)
        if (isLive(j, tNow) && emLocA[j] == (rloc & 12'hfff)) pend.push_back(j);
    end
    ovfExp = 0;
    if (ev) begin
      if (nEm >= SLOTS) begin
        int old;
        old    = nEm - SLOTS;
        ovfExp = isLive(old, tNow);
        for (int q = 0; q < pend.size(); q++)
          if (pend[q] == old) begin
            pend.delete(q);
            break;
          end
      end
      emIdA[nEm]  = id & 8'hff;
      emLocA[nEm] = loc & 12'hfff;
      emTA[nEm]   = tNow;
      nEm++;
    end
    tNow++;
    emitValid = 1'b0;
    rptValid  = 1'b0;
    @(negedge clk);
    modelCheck();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd2718);
    rstN = 1'b0; emitValid = 0; emitId = '0; emitLoc = '0; rptValid = 0; rptLoc = '0;
    repeat (3) @(negedge clk);
    chk("R9", "busy in reset", int'(busy), 0);
    chk("R9", "recValid in reset", int'(recValid), 0);
    chk("R9", "overwrite in reset", int'(overwrite), 0);
    rstN = 1'b1;

    // R1/R2: retention boundary, last matching edge and first missing edge
    step(1, 5, 100, 0, 0);
    idle(LAT - 1);
    step(0, 0, 0, 1, 100);
    chk("R1", "recorded entry recalled", int'(recValid), 1);
    chk("R2", "id at retention limit", int'(recId), 5);
    idle(1);
    step(1, 6, 101, 0, 0);
    idle(LAT);
    step(0, 0, 0, 1, 101);
    chk("R2", "expired entry recalled", int'(recValid), 0);

    // R3/R5: oldest first, a report during the stream is ignored
    step(1, 10, 300, 0, 0);
    step(1, 99, 301, 0, 0);
    step(1, 11, 300, 0, 0);
    step(1, 12, 300, 0, 0);
    step(0, 0, 0, 1, 300);
    chk("R3", "first streamed id", int'(recId), 10);
    step(0, 0, 0, 1, 301);
    chk("R3", "second streamed id", int'(recId), 11);
    step(0, 0, 0, 0, 0);
    chk("R3", "third streamed id", int'(recId), 12);
    step(0, 0, 0, 0, 0);
    chk("R5", "report while busy ignored", int'(recValid), 0);
    step(0, 0, 0, 1, 777);
    chk("R5", "no-match report busy", int'(busy), 0);

    // R8/R6: same-edge emission excluded, emission during recall kept
    step(1, 17, 400, 0, 0);
    step(1, 18, 400, 0, 0);
    step(1, 19, 400, 0, 0);
    step(1, 20, 400, 1, 400);
    chk("R8", "stream starts at oldest", int'(recId), 17);
    step(1, 21, 401, 0, 0);
    chk("R6", "stream continues during emission", int'(recId), 18);
    step(0, 0, 0, 0, 0);
    chk("R8", "last older match", int'(recId), 19);
    step(0, 0, 0, 0, 0);
    chk("R8", "same-edge emission not streamed", int'(recValid), 0);
    step(0, 0, 0, 1, 401);
    chk("R6", "emission during recall recalled", int'(recId), 21);
    idle(1);

    // R7: fill every slot with live records, then one more
    idle(LAT + 2);
    for (int k = 0; k < SLOTS; k++) step(1, 40 + k, 500 + k, 0, 0);
    chk("R7", "no overwrite while filling", int'(overwrite), 0);
    step(1, 90, 600, 0, 0);
    chk("R7", "overwrite flag raised", int'(overwrite), 1);
    step(0, 0, 0, 1, 500);
    chk("R7", "overwritten entry gone", int'(recValid), 0);
    chk("R7", "flag lasts one cycle", int'(overwrite), 0);
    step(0, 0, 0, 1, 501);
    chk("R7", "second oldest kept", int'(recId), 41);
    idle(1);

    // Random phases with sparse, medium and dense contribution rates
    for (int n = 0; n < 2400; n++) begin
      int rate;
      rate = (n < 800) ? 30 : ((n < 1600) ? 95 : 60);
      step(($urandom % 100) < rate, $urandom % 256, 800 + ($urandom % 6),
           ($urandom % 100) < 12, 800 + ($urandom % 6));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule